// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Tag Lookup

This block performs the tag lookup of a small direct-mapped instruction cache. Each cycle in which the fetch unit presents a valid program counter, the block decides whether the containing 32-byte block is resident. If it is not, the block also decides whether the block has ever been fetched since reset. The verdict appears on the outputs one clock later as exactly one of three flags: hit, first-touch (compulsory) miss, or repeat (non-compulsory) miss.

Instruction memory is never written, so lines carry only a tag and a valid bit and have no dirty state. The address is 16 bits wide. Bits [4:0] select a byte within the block, bits [9:5] pick one of 32 lines, and bits [15:10] form the tag. On any miss the new tag is installed at once, whatever the line held before. A history bitmap with one bit for each of the 2048 memory blocks, indexed by bits [15:5], remembers which blocks have been fetched before. Data storage and refill are handled elsewhere.

Top module: `fetch_tag_classifier`

## Requirements
- R1: After reset `res_vld` and all three flags are low and every line is invalid, so the first fetch of any address reports a compulsory miss.
- R2: `res_vld` equals `fetch_vld` from the previous cycle. When `res_vld` is high exactly one of `res_hit`, `res_cold`, `res_warm` is high. When it is low all three are low.
- R3: A fetch hits when the line selected by pc[9:5] is valid and its stored tag equals pc[15:10].
- R4: A fetch that misses installs pc[15:10] into its line and marks the line valid, so the next fetch of the same block hits.
- R5: A miss overwrites whatever the line held. A later fetch of the evicted block misses.
- R6: A miss to a block (pc[15:5]) never fetched since reset is reported on `res_cold`.
- R7: A miss to a block fetched earlier since reset is reported on `res_warm`.
- R8: Byte offset bits pc[4:0] do not affect the result. Any two addresses in one block behave the same.
- R9: A fetch in the cycle right after another fetch sees that fetch's update. A miss followed at once by a fetch of the same block gives a hit.
- R10: While `fetch_vld` is low, `fetch_pc` has no effect on the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_vld | input | 1 | Fetch request this cycle |
| fetch_pc | input | 16 | Fetch byte address |
| res_vld | output | 1 | Result for the previous cycle's fetch |
| res_hit | output | 1 | Block was resident |
| res_cold | output | 1 | Miss on a block never fetched before |
| res_warm | output | 1 | Miss on a block fetched before |

## Verification
The repeat miss is the hardest outcome to provoke from the ports. It needs a block to be fetched, then evicted by another tag on the same line, and then fetched again. Uniform random addresses almost never do this across 2048 blocks. The random stimulus therefore draws from four tags and four line indices with random offsets, which produces frequent conflicts and evictions. Directed sequences cover the eviction ping-pong, back-to-back same-line fetches, and address changes while no fetch is requested.

// File: rtl/fetch_tag_classifier.sv
module fetch_tag_classifier #(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 5,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_vld,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              res_vld,
  output logic              res_hit,
  output logic              res_cold,
  output logic              res_warm
);
  localparam int TAG_W  = ADDR_W - OFFS_W - IDX_W;
  localparam int BLK_W  = ADDR_W - OFFS_W;
  localparam int LINES  = 1 << IDX_W;
  localparam int BLOCKS = 1 << BLK_W;

  logic [TAG_W-1:0]  tag_q [LINES];
  logic [LINES-1:0]  valid_q;
  logic [BLOCKS-1:0] seen_q;

  wire [IDX_W-1:0] idx = fetch_pc[OFFS_W +: IDX_W];
  wire [TAG_W-1:0] tag = fetch_pc[ADDR_W-1 -: TAG_W];
  wire [BLK_W-1:0] blk = fetch_pc[ADDR_W-1 -: BLK_W];
  wire unused_offset = ^fetch_pc[OFFS_W-1:0];

  wire hit  = valid_q[idx] && (tag_q[idx] == tag);
  wire cold = !hit && !seen_q[blk];
  wire fill = fetch_vld && !hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= '0;
      seen_q   <= '0;
      res_vld  <= 1'b0;
      res_hit  <= 1'b0;
      res_cold <= 1'b0;
      res_warm <= 1'b0;
    end else begin
      res_vld  <= fetch_vld;
      res_hit  <= fetch_vld && hit;
      res_cold <= fetch_vld && cold;
      res_warm <= fetch_vld && !hit && !cold;
      if (fill) begin
        valid_q[idx] <= 1'b1;
        seen_q[blk]  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill) tag_q[idx] <= tag;
  end
endmodule

module fetch_tag_classifier_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_vld,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              res_vld,
  input logic              res_hit,
  input logic              res_cold,
  input logic              res_warm
);
  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $onehot({res_hit, res_cold, res_warm})); // R2

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> !(res_hit || res_cold || res_warm)); // R2

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld |=> res_vld); // R2

  AST_REPEAT_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && $past(fetch_vld) && $past(rst_n) &&
     fetch_pc[ADDR_W-1:5] == $past(fetch_pc[ADDR_W-1:5])) |=> res_hit); // R9
endmodule

bind fetch_tag_classifier fetch_tag_classifier_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
  .res_vld(res_vld), .res_hit(res_hit), .res_cold(res_cold), .res_warm(res_warm)
);

// File: tb/fetch_tag_classifier_bench.sv
`timescale 1ns/1ps
module fetch_tag_classifier_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_vld = 1'b0;
  logic [15:0] fetch_pc = '0;
  logic res_vld, res_hit, res_cold, res_warm;

  fetch_tag_classifier u_fetch_tag_classifier (
    .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
    .res_vld(res_vld), .res_hit(res_hit), .res_cold(res_cold), .res_warm(res_warm)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [5:0] m_tag  [32];
  bit         m_val  [32];
  bit         m_seen [2048];

  int    exp_cls = 0;
  string exp_req = "R1";

  // 0 idle, 1 hit, 2 compulsory, 3 repeat miss
  function automatic int classify(input logic [15:0] pc);
    if (m_val[pc[9:5]] && m_tag[pc[9:5]] == pc[15:10]) return 1;
    if (!m_seen[pc[15:5]]) return 2;
    return 3;
  endfunction

  function automatic string cls_req(input int c);
    case (c)
      1: return "R3";
      2: return "R6";
      3: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check_out();
    int act;
    act = !res_vld ? 0 : (res_hit && !res_cold && !res_warm) ? 1 :
          (res_cold && !res_hit && !res_warm) ? 2 :
          (res_warm && !res_hit && !res_cold) ? 3 : 9;
    if (!res_vld && (res_hit || res_cold || res_warm)) act = 8;
    checks++;
    if (act != exp_cls) begin
      fails++;
      $display("FAIL %s/%s: class actual %0d expected %0d", exp_req, cls_req(exp_cls), act, exp_cls);
    end
  endtask

  task automatic step(input bit vld, input logic [15:0] pc, input string req);
    @(negedge clk);
    check_out();
    fetch_vld = vld;
    fetch_pc  = pc;
    exp_req   = req;
    if (vld) begin
      exp_cls = classify(pc);
      if (exp_cls != 1) begin
        m_tag[pc[9:5]]  = pc[15:10];
        m_val[pc[9:5]]  = 1'b1;
        m_seen[pc[15:5]] = 1'b1;
      end
    end else exp_cls = 0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_val[i] = 1'b0;
    for (int i = 0; i < 2048; i++) m_seen[i] = 1'b0;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    checks++;
    if (res_vld !== 1'b0) begin
      fails++;
      $display("FAIL R1: res_vld actual %b expected 0", res_vld);
    end
    rst_n = 1'b1;
    step(1, 16'hCA12, "R1");
    step(1, 16'hCA13, "R9");
    step(1, 16'hCA1F, "R8");
    step(1, 16'hCA00, "R8");
    step(1, 16'hCA23, "R6");
    step(0, 16'h1234, "R10");
    step(0, 16'h5234, "R10");
    step(0, 16'h9234, "R10");
    step(1, 16'h1234, "R10");
    step(1, 16'h1238, "R4");
    step(1, 16'h5234, "R5");
    step(1, 16'h1234, "R5");
    step(1, 16'h5234, "R7");
    step(1, 16'h5234, "R9");
    step(1, 16'hFE15, "R6");
    step(1, 16'hFE13, "R8");
    step(1, 16'hFE23, "R6");
    step(1, 16'hFE14, "R3");
    step(1, 16'hFE24, "R3");
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] pc;
      pc = {4'($urandom_range(0, 3)), 2'b10, 3'($urandom_range(0, 3)), 2'b01, 5'($urandom)};
      step(($urandom_range(0, 9) < 8), pc, "R5");
    end
    step(0, 16'h0, "R2");
    step(0, 16'h0, "R2");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule